// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block is a PWM generator with eight outputs that all run off a single 16-bit up-counter. The counter starts at a programmable initial count, climbs to a programmable modulo value and then returns to the initial count, so every channel shares one period. A power-of-two prescaler sets the counting rate. The counter clock is one of three sources: every bus clock cycle, a fixed-rate enable strobe, or an external enable strobe. Both strobes are synchronous to the bus clock, so the whole block lives in one clock domain.

Each channel compares the shared count against its own compare value to form an edge-aligned pulse. A per-channel control field selects high-true pulses, low-true pulses or a parked-low output. After that, a per-channel polarity bit can invert the result. A per-channel mask bit overrides everything and drives a defined idle level. Software programs the block through a simple 32-bit register bus with byte addresses on 4-byte word boundaries. Write data is taken on the clock edge where the write strobe is high, and read data comes back on a register one cycle after the address is presented. A status register latches a per-channel match flag, which software clears by writing 1 to the flag.

Register layout (byte offsets): control word 0x00, live count 0x04, modulo 0x08, initial count 0x4C, match flags 0x50, idle levels 0x5C, mask 0x60, polarity 0x70. Channel n uses two registers: its mode field at 0x0C+8n and its compare value at 0x10+8n.

Top module: `pwm_timer8`

## Requirements
- R1: After reset every register reads zero except the mask register, which reads 0xFF. The live count is 0 and `pwm_out` is all zeros.
- R2: Control-word bits [4:3] pick the counter clock: 0 holds the count still, 1 advances on every cycle, 2 advances on cycles where `fix_tick` is high, and 3 advances on cycles where `ext_tick` is high.
- R3: Control-word bits [2:0] hold a code P. The count advances once per 2^P selected clock ticks.
- R4: On an advance, a count at or above the modulo value reloads the initial count; otherwise the count increments. Writing any value to the live-count register (0x04) reloads it with the initial count.
- R5: With initial count I and modulo M (I <= M), the period is M-I+1 advances.
- R6: Channel mode bits sit at register bits 5, 4, 3 and 2. The channel is active while the count is below its compare value V. With bits 5 and 3 set, the output before polarity is high while active. With bit 5 set, bit 3 clear and bit 2 set, the output is low while active. Any other setting parks the output low.
- R7: A compare value greater than the modulo gives an output that is active for the whole period. A compare value of 0 gives an output that is never active.
- R8: Polarity bit n set inverts channel n's unmasked output.
- R9: Mask bit n set forces `pwm_out[n]` to idle-level bit n XOR polarity bit n, independent of the count. `pwm_out` is registered and reflects the settings and count of the previous cycle.
- R10: Match flag n is set when the count advances from a value equal to channel n's compare value. Writing 1 to a flag bit clears it. A set in the same cycle as the clear takes priority.
- R11: Unmapped or misaligned addresses read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| fix_tick | input | 1 | Fixed-rate counter enable strobe |
| ext_tick | input | 1 | External counter enable strobe |
| pwm_out | output | 8 | Channel outputs, registered |

## Verification
A write lands on the rising edge where `bus_wr` is high. Read data appears one edge after the address is applied. `pwm_out` follows the count and the settings with one register of delay, so a mask or polarity change shows up one cycle after its write. The bench drives all stimulus on falling edges and samples on the falling edge after the result is due. Duty cycles are measured by counting high samples over a whole number of periods, once the output has settled for more than one period after a reconfiguration. That makes the expected counts independent of phase. Match flags are checked only after the counter has been stopped, so no advance can set a flag between the clear and the read.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MOD   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CH    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_IDLE  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h70;

  // counter clock source, encoded as control-word bits [4:3]
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;
endpackage

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_timer8_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  src_e          src,
  input  logic [PSW-1:0] ps,
  input  logic          fix_tick,
  input  logic          ext_tick,
  input  logic [CW-1:0] mod_val,
  input  logic [CW-1:0] init_val,
  input  logic          reload,
  output logic [CW-1:0] cnt,
  output logic          step
);
  localparam int DIVW = (1 << PSW) - 1;

  logic            src_tick;
  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] div_mask;

  always_comb begin
    case (src)
      SRC_SYS: src_tick = 1'b1;
      SRC_FIX: src_tick = fix_tick;
      SRC_EXT: src_tick = ext_tick;
      default: src_tick = 1'b0;
    endcase
  end

  // low P bits of the divider must all be ones for an advance
  always_comb begin
    for (int i = 0; i < DIVW; i++) begin
      div_mask[i] = (i < int'(ps));
    end
  end

  assign step = src_tick && ((div_q & div_mask) == div_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
    end else begin
      if (src_tick) div_q <= div_q + 1'b1;
      if (reload) begin
        cnt <= init_val;
      end else if (step) begin
        if (cnt >= mod_val) cnt <= init_val;
        else                cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          step,
  input  logic [CW-1:0] cv,
  input  logic [3:0]    mode,   // register bits 5..2
  input  logic          pol,
  input  logic          mask,
  input  logic          idle,
  output logic          out_q,
  output logic          hit
);
  logic active;
  logic level;

  assign active = (cnt < cv);
  assign hit    = step && (cnt == cv);

  always_comb begin
    if (mode[3] && mode[1])      level = active;
    else if (mode[3] && mode[0]) level = ~active;
    else                         level = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       out_q <= 1'b0;
    else if (mask) out_q <= idle ^ pol;
    else           out_q <= level ^ pol;
  end
endmodule

// File: rtl/pwm_bus_regs.sv
module pwm_bus_regs
  import pwm_timer8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [CW-1:0]     cnt,
  input  logic [NCH-1:0]    hit,
  output src_e              src,
  output logic [PSW-1:0]    ps,
  output logic [CW-1:0]     mod_val,
  output logic [CW-1:0]     init_val,
  output logic              reload,
  output logic [NCH*4-1:0]  mode_flat,
  output logic [NCH*CW-1:0] cv_flat,
  output logic [NCH-1:0]    pol,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    idle,
  output logic [NCH-1:0]    flags
);
  localparam int CIW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CH_END = int'(OFS_CH) + 8 * NCH;

  logic [3:0]        mode_q [NCH];
  logic [CW-1:0]     cv_q   [NCH];
  logic              aligned;
  logic              in_ch;
  logic [ADDR_W-1:0] rel;
  logic [CIW-1:0]    ch_idx;
  logic              is_cv;
  logic [NCH-1:0]    flag_clr;
  logic [31:0]       rd_d;

  wire unused_wdata = ^bus_wdata[31:CW];

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign in_ch   = aligned && (int'(bus_addr) >= int'(OFS_CH)) && (int'(bus_addr) < CH_END);
  assign rel     = bus_addr - OFS_CH;
  assign ch_idx  = rel[3 +: CIW];
  assign is_cv   = rel[2];
  assign reload  = bus_wr && aligned && (bus_addr == OFS_CNT);
  assign flag_clr = (bus_wr && aligned && bus_addr == OFS_FLAG) ? bus_wdata[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign mode_flat[g*4 +: 4]  = mode_q[g];
    assign cv_flat[g*CW +: CW]  = cv_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src      <= SRC_OFF;
      ps       <= '0;
      mod_val  <= '0;
      init_val <= '0;
      pol      <= '0;
      mask     <= '1;
      idle     <= '0;
      flags    <= '0;
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        cv_q[i]   <= '0;
      end
    end else begin
      flags <= (flags & ~flag_clr) | hit;
      if (bus_wr && aligned) begin
        case (bus_addr)
          OFS_CTL: begin
            src <= src_e'(bus_wdata[4:3]);
            ps  <= bus_wdata[PSW-1:0];
          end
          OFS_MOD:  mod_val  <= bus_wdata[CW-1:0];
          OFS_INIT: init_val <= bus_wdata[CW-1:0];
          OFS_IDLE: idle     <= bus_wdata[NCH-1:0];
          OFS_MASK: mask     <= bus_wdata[NCH-1:0];
          OFS_POL:  pol      <= bus_wdata[NCH-1:0];
          default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
          if (in_ch && int'(ch_idx) == i) begin
            if (is_cv) cv_q[i]   <= bus_wdata[CW-1:0];
            else       mode_q[i] <= bus_wdata[5:2];
          end
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      case (bus_addr)
        OFS_CTL: begin
          rd_d[4:3]     = src;
          rd_d[PSW-1:0] = ps;
        end
        OFS_CNT:  rd_d[CW-1:0]  = cnt;
        OFS_MOD:  rd_d[CW-1:0]  = mod_val;
        OFS_INIT: rd_d[CW-1:0]  = init_val;
        OFS_FLAG: rd_d[NCH-1:0] = flags;
        OFS_IDLE: rd_d[NCH-1:0] = idle;
        OFS_MASK: rd_d[NCH-1:0] = mask;
        OFS_POL:  rd_d[NCH-1:0] = pol;
        default: begin
          for (int i = 0; i < NCH; i++) begin
            if (in_ch && int'(ch_idx) == i) begin
              if (is_cv) rd_d[CW-1:0] = cv_q[i];
              else       rd_d[5:2]    = mode_q[i];
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              fix_tick,
  input  logic              ext_tick,
  output logic [NCH-1:0]    pwm_out
);
  src_e              src_w;
  logic [PSW-1:0]    ps_w;
  logic [CW-1:0]     mod_w;
  logic [CW-1:0]     init_w;
  logic              reload_w;
  logic [CW-1:0]     cnt_w;
  logic              step_w;
  logic [NCH*4-1:0]  mode_w;
  logic [NCH*CW-1:0] cv_w;
  logic [NCH-1:0]    pol_w;
  logic [NCH-1:0]    mask_w;
  logic [NCH-1:0]    idle_w;
  logic [NCH-1:0]    flags_w;
  logic [NCH-1:0]    hit_w;

  pwm_bus_regs #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt_w), .hit(hit_w),
    .src(src_w), .ps(ps_w), .mod_val(mod_w), .init_val(init_w),
    .reload(reload_w), .mode_flat(mode_w), .cv_flat(cv_w), .pol(pol_w),
    .mask(mask_w), .idle(idle_w), .flags(flags_w)
  );

  pwm_count_core #(.CW(CW), .PSW(PSW)) u_core (
    .clk(clk), .rst(rst), .src(src_w), .ps(ps_w), .fix_tick(fix_tick),
    .ext_tick(ext_tick), .mod_val(mod_w), .init_val(init_w),
    .reload(reload_w), .cnt(cnt_w), .step(step_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt_w), .step(step_w),
      .cv(cv_w[g*CW +: CW]), .mode(mode_w[g*4 +: 4]), .pol(pol_w[g]),
      .mask(mask_w[g]), .idle(idle_w[g]), .out_q(pwm_out[g]), .hit(hit_w[g])
    );
  end
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
  import pwm_timer8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     mod_val,
  input logic [CW-1:0]     init_val,
  input logic [1:0]        src,
  input logic              step,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    mask,
  input logic [NCH-1:0]    pol,
  input logic [NCH-1:0]    idle,
  input logic [NCH-1:0]    flags
);
  logic cnt_wr;
  logic flag_wr;
  assign cnt_wr  = bus_wr && (bus_addr == OFS_CNT);
  assign flag_wr = bus_wr && (bus_addr == OFS_FLAG);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask == '1 && cnt == '0 && pwm_out == '0));

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (src == 2'd0 && !cnt_wr) |=> $stable(cnt));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && cnt >= mod_val) |=> (cnt == $past(init_val)));

  a_r4_increment: assert property (@(posedge clk) disable iff (rst)
    (step && cnt < mod_val && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

  a_r9_masked_level: assert property (@(posedge clk) disable iff (rst)
    (((pwm_out ^ $past(idle ^ pol)) & $past(mask)) == '0));

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !flag_wr) |=> $stable(flags));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cnt(cnt_w), .mod_val(mod_w), .init_val(init_w), .src(src_w),
  .step(step_w), .pwm_out(pwm_out), .mask(mask_w), .pol(pol_w),
  .idle(idle_w), .flags(flags_w)
);

// File: tb/tb_pwm_timer8.sv
module tb_pwm_timer8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fix_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic [7:0]  pwm_out;
  logic        fix_run = 1'b0;

  int checks = 0;
  int errors = 0;
  int hi [8];

  pwm_timer8 dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fix_tick(fix_tick),
    .ext_tick(ext_tick), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (fix_run) fix_tick <= ~fix_tick;
    else         fix_tick <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < 8; c++) hi[c] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < 8; c++) hi[c] += int'(pwm_out[c]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pwm_out after reset", {24'd0, pwm_out}, 32'h0);
    rd(8'h60, d); chk("R1 mask reset", d, 32'hFF);
    rd(8'h00, d); chk("R1 control reset", d, 32'h0);
    rd(8'h04, d); chk("R1 count reset", d, 32'h0);
  endtask

  task automatic t_stop_unmapped;
    logic [31:0] a, b;
    wr(8'h08, 32'd9);
    idle_cycles(5);
    rd(8'h04, a); idle_cycles(6); rd(8'h04, b);
    chk("R2 source 0 holds count", b, a);
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, a); chk("R11 unmapped reads zero", a, 32'h0);
    wr(8'h02, 32'h1F);
    rd(8'h00, a); chk("R11 misaligned write ignored", a, 32'h0);
    rd(8'h60, a); chk("R11 mask untouched", a, 32'hFF);
  endtask

  task automatic t_basic;
    wr(8'h0C, 32'h28); wr(8'h10, 32'd3);   // ch0 high-true, cv 3
    wr(8'h14, 32'h28); wr(8'h18, 32'd15);  // ch1 cv > mod
    wr(8'h1C, 32'h28); wr(8'h20, 32'd0);   // ch2 cv 0
    wr(8'h2C, 32'h24); wr(8'h30, 32'd3);   // ch4 low-true
    wr(8'h34, 32'h00); wr(8'h38, 32'd3);   // ch5 parked
    wr(8'h60, 32'h08);
    wr(8'h00, 32'h08);
    idle_cycles(12);
    measure(20);
    chk("R6 ch0 high-true duty", hi[0], 6);
    chk("R7 ch1 cv above mod", hi[1], 20);
    chk("R7 ch2 cv zero", hi[2], 0);
    chk("R6 ch4 low-true duty", hi[4], 14);
    chk("R6 ch5 parked low", hi[5], 0);
  endtask

  task automatic t_polarity;
    wr(8'h70, 32'h01);
    idle_cycles(3);
    measure(20);
    chk("R8 ch0 inverted duty", hi[0], 14);
    wr(8'h70, 32'h00);
  endtask

  task automatic t_mask;
    wr(8'h5C, 32'h08);
    idle_cycles(2);
    measure(20);
    chk("R9 masked ch3 idle high", hi[3], 20);
    wr(8'h70, 32'h08);
    @(negedge clk);
    chk("R9 mask level one cycle after polarity write", {31'd0, pwm_out[3]}, 32'd0);
    wr(8'h60, 32'h09);
    idle_cycles(2);
    measure(20);
    chk("R9 masked ch0 forced low", hi[0], 0);
    wr(8'h60, 32'h08); wr(8'h70, 32'h00); wr(8'h5C, 32'h00);
  endtask

  task automatic t_prescale;
    wr(8'h00, 32'h0A);
    idle_cycles(50);
    measure(80);
    chk("R3 prescale 4 duty", hi[0], 24);
  endtask

  task automatic t_source;
    logic [31:0] a, b;
    fix_run = 1'b1;
    wr(8'h00, 32'h10);
    idle_cycles(30);
    measure(40);
    chk("R2 fixed strobe source", hi[0], 12);
    wr(8'h00, 32'h18);
    fix_run = 1'b0;
    idle_cycles(3);
    rd(8'h04, a); idle_cycles(8); rd(8'h04, b);
    chk("R2 external source without strobe", b, a);
  endtask

  task automatic t_init;
    logic [31:0] d;
    wr(8'h00, 32'h00);
    wr(8'h4C, 32'd5);
    wr(8'h04, 32'h1234);
    rd(8'h04, d); chk("R4 count write reloads initial", d, 32'd5);
    wr(8'h10, 32'd7);
    wr(8'h00, 32'h08);
    idle_cycles(20);
    measure(20);
    chk("R5 initial count period", hi[0], 8);
    wr(8'h00, 32'h00);
    wr(8'h4C, 32'd0);
    wr(8'h10, 32'd3);
  endtask

  task automatic t_flags;
    logic [31:0] d;
    wr(8'h04, 32'd0);
    wr(8'h00, 32'h08);
    idle_cycles(25);
    wr(8'h00, 32'h00);
    rd(8'h50, d); chk("R10 flags ch0 set ch1 clear", d & 32'h3, 32'h1);
    wr(8'h50, 32'h01);
    rd(8'h50, d); chk("R10 write one clears", d & 32'h3, 32'h0);
    chk("R10 other flags kept", d & 32'h4, 32'h4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stop_unmapped();
    t_basic();
    t_polarity();
    t_mask();
    t_prescale();
    t_source();
    t_init();
    t_flags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule